// File: doc/BRIEF.md
# SPI Channel FIFO, Status and Interrupt Unit

This block is the register-side half of one chip-select channel of a serial peripheral interface controller. Software fills a transmit word queue and drains a receive word queue through a small register window. A separate shift engine pulls transmit words, pushes received words and reports the end of each transfer. The engine connects through single-cycle request and valid strobes.

The unit keeps a status word. Bit 0 shows that a transfer is in progress. Bits 1 to 5 are sticky event flags: end of transfer, transmit queue low, receive queue high, transmit starvation and receive drop. Software clears a sticky flag by writing a one to its position. An interrupt-enable register masks the five sticky flags onto a single interrupt line. A shared threshold register sets the low mark for the transmit queue and the high mark for the receive queue. A word-count register reports how full both queues are.

Register word addresses: 0 status, 1 interrupt enable, 2 thresholds, 3 word counts, 4 transmit data (write), 5 receive data (read). Reads of other addresses return zero, and writes to them are ignored.

Top module: `spi_buf_irq_unit`

## Requirements
- R1: While reset is held and at its release, the status, word-count and interrupt-enable registers read zero and the interrupt line is low. The threshold register reads 0x80, which means transmit low mark 0 and receive high mark 8.
- R2: A write to address 4 enqueues a word in an 8-deep transmit queue. Each engine request takes the oldest word onto eng_tx_word in the same cycle. The word-count register reports transmit occupancy in bits [7:4].
- R3: Each eng_rx_valid strobe enqueues eng_rx_word in an 8-deep receive queue. A read of address 5 returns the oldest word and removes it. The word-count register reports receive occupancy in bits [3:0].
- R4: A write to address 4 while the transmit queue holds 8 words is ignored. A read of address 5 from an empty receive queue returns zero and changes nothing.
- R5: Status bit 0 follows eng_busy, and writes do not affect it. Status bit 1 sets on an eng_done strobe and stays set until it is cleared.
- R6: The threshold register holds the transmit low mark in bits [3:0] and the receive high mark in bits [7:4]. Status bit 2 sets in every cycle in which transmit occupancy is at or below the low mark. Status bit 3 sets in every cycle in which receive occupancy is at or above the high mark.
- R7: An engine request while eng_busy is high and the transmit queue is empty sets status bit 4, and eng_tx_word is zero.
- R8: An eng_rx_valid strobe while the receive queue holds 8 words sets status bit 5, and the word is dropped.
- R9: A write to address 0 clears each sticky bit written as one and leaves the bits written as zero. A set condition in the same cycle wins over the clear.
- R10: irq is high when any masked sticky flag is set. Enable bit 0 masks status bit 1, and enable bits 1 to 4 mask status bits 2 to 5. Writing zero to the enables drops irq in the next cycle.
- R11: Full and empty are judged on the occupancy held before the cycle. A software write and an engine request in the same cycle on a full transmit queue leave 7 words, and the written word is lost. A software read and an engine push in the same cycle on an empty receive queue return zero and leave 1 word. At a middle occupancy, a push and a pop in the same cycle keep the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 5) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the address |
| eng_busy | input | 1 | Engine has a transfer in progress |
| eng_done | input | 1 | Engine end-of-transfer strobe |
| eng_tx_req | input | 1 | Engine takes one transmit word |
| eng_tx_word | output | DATA_W | Oldest transmit word, zero when empty |
| eng_rx_valid | input | 1 | Engine delivers one received word |
| eng_rx_word | input | DATA_W | Received word |
| irq | output | 1 | Interrupt line |

## Verification
Several pairs of functions can land in the same clock: a software push and an engine pop on one queue, a software pop and an engine push on the other, and a write-one clear with a new set event on a status bit. The bench drives both strobes on the same falling edge at the empty, full and middle occupancies. It then judges the outcome from the returned data, the word-count register and the words drained afterwards. The threshold flags are swept over every occupancy and every mark in a single sweep.

// File: rtl/spq_pkg.sv
package spq_pkg;
  localparam int ADDR_W = 3;
  localparam int FLD_W  = 4;
  localparam int NUM_ST = 6;
  localparam int NUM_IE = 5;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_THR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_WCNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd5;

  localparam int ST_PEND = 0;
  localparam int ST_DONE = 1;
  localparam int ST_TXLO = 2;
  localparam int ST_RXHI = 3;
  localparam int ST_TXUF = 4;
  localparam int ST_RXOF = 5;

  // Word-count layout: receive in the low field, transmit above it.
  function automatic logic [2*FLD_W-1:0] pack_wcnt(input logic [FLD_W-1:0] rxc,
                                                   input logic [FLD_W-1:0] txc);
    return {txc, rxc};
  endfunction

  function automatic logic tx_low(input logic [FLD_W-1:0] cnt,
                                  input logic [FLD_W-1:0] mark);
    return cnt <= mark;
  endfunction

  function automatic logic rx_high(input logic [FLD_W-1:0] cnt,
                                   input logic [FLD_W-1:0] mark);
    return cnt >= mark;
  endfunction

  // Enable bit k masks status bit k+1.
  function automatic logic irq_reduce(input logic [NUM_ST-1:0] st,
                                      input logic [NUM_IE-1:0] en);
    return |(st[NUM_ST-1:1] & en);
  endfunction
endpackage

// File: rtl/spq_fifo.sv
module spq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] pop_data_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o     = (cnt == CW'(DEPTH));
  assign empty_o    = (cnt == '0);
  assign push_ok    = push_i && !full_o;
  assign pop_ok     = pop_i && !empty_o;
  assign pop_data_o = empty_o ? '0 : mem[rd_ptr];
  assign count_o    = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
      else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data_i;
  end
endmodule

// File: rtl/spq_status.sv
module spq_status
  import spq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic [NUM_ST-1:1] set_i,
  input  logic              clr_we_i,
  input  logic [NUM_ST-1:0] clr_mask_i,
  output logic [NUM_ST-1:0] status_o
);
  logic [NUM_ST-1:1] sticky;

  // Set wins over write-one clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= '0;
    end else begin
      for (int b = 1; b < NUM_ST; b++) begin
        if (set_i[b])                         sticky[b] <= 1'b1;
        else if (clr_we_i && clr_mask_i[b])   sticky[b] <= 1'b0;
      end
    end
  end

  assign status_o = {sticky, busy_i};
endmodule

// File: rtl/spq_regif.sv
module spq_regif
  import spq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_ST-1:0]  status_i,
  input  logic [2*FLD_W-1:0] wcnt_i,
  input  logic [DATA_W-1:0]  rx_word_i,
  output logic [NUM_IE-1:0]  ien_o,
  output logic [FLD_W-1:0]   thr_tx_o,
  output logic [FLD_W-1:0]   thr_rx_o,
  output logic               st_clr_o,
  output logic               tx_push_o,
  output logic               rx_pop_o
);
  localparam logic [FLD_W-1:0] RX_MARK_RST = FLD_W'(DEPTH);

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:2*FLD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_o    <= '0;
      thr_tx_o <= '0;
      thr_rx_o <= RX_MARK_RST;
    end else if (wr_i) begin
      if (addr_i == A_IEN) ien_o <= wdata_i[NUM_IE-1:0];
      if (addr_i == A_THR) begin
        thr_tx_o <= wdata_i[FLD_W-1:0];
        thr_rx_o <= wdata_i[2*FLD_W-1:FLD_W];
      end
    end
  end

  assign st_clr_o  = wr_i && (addr_i == A_STAT);
  assign tx_push_o = wr_i && (addr_i == A_TXD);
  assign rx_pop_o  = rd_i && (addr_i == A_RXD);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_STAT:  rdata_o = DATA_W'(status_i);
      A_IEN:   rdata_o = DATA_W'(ien_o);
      A_THR:   rdata_o = DATA_W'({thr_rx_o, thr_tx_o});
      A_WCNT:  rdata_o = DATA_W'(wcnt_i);
      A_RXD:   rdata_o = rx_word_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_buf_irq_unit.sv
module spi_buf_irq_unit
  import spq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              eng_tx_req,
  output logic [DATA_W-1:0] eng_tx_word,
  input  logic              eng_rx_valid,
  input  logic [DATA_W-1:0] eng_rx_word,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // Named internal events, visible to the bound checker.
  logic [CNT_W-1:0]   tx_cnt, rx_cnt;
  logic               tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0]  rx_head;
  logic               tx_push, rx_pop, st_clr;
  logic [NUM_IE-1:0]  ien;
  logic [FLD_W-1:0]   thr_tx, thr_rx;
  logic [NUM_ST-1:0]  status;
  logic [2*FLD_W-1:0] wcnt;
  logic               ev_done, ev_tx_low, ev_rx_high, ev_tx_starve, ev_rx_drop;
  logic [NUM_ST-1:1]  st_set;
  logic               unused_flags;

  assign unused_flags = tx_full ^ rx_empty;

  spq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH), .CW(CNT_W)) i_txq (
    .clk(clk), .rst_n(rst_n),
    .push_i(tx_push), .push_data_i(reg_wdata),
    .pop_i(eng_tx_req), .pop_data_o(eng_tx_word),
    .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  spq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH), .CW(CNT_W)) i_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_i(eng_rx_valid), .push_data_i(eng_rx_word),
    .pop_i(rx_pop), .pop_data_o(rx_head),
    .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  assign wcnt = pack_wcnt(FLD_W'(rx_cnt), FLD_W'(tx_cnt));

  assign ev_done      = eng_done;
  assign ev_tx_low    = tx_low(FLD_W'(tx_cnt), thr_tx);
  assign ev_rx_high   = rx_high(FLD_W'(rx_cnt), thr_rx);
  assign ev_tx_starve = eng_busy && eng_tx_req && tx_empty;
  assign ev_rx_drop   = eng_rx_valid && rx_full;
  assign st_set       = {ev_rx_drop, ev_tx_starve, ev_rx_high, ev_tx_low, ev_done};

  spq_status i_stat (
    .clk(clk), .rst_n(rst_n), .busy_i(eng_busy), .set_i(st_set),
    .clr_we_i(st_clr), .clr_mask_i(reg_wdata[NUM_ST-1:0]), .status_o(status)
  );

  spq_regif #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .status_i(status), .wcnt_i(wcnt),
    .rx_word_i(rx_head), .ien_o(ien), .thr_tx_o(thr_tx), .thr_rx_o(thr_rx),
    .st_clr_o(st_clr), .tx_push_o(tx_push), .rx_pop_o(rx_pop)
  );

  assign irq = irq_reduce(status, ien);
endmodule

// File: rtl/spq_chk.sv
module spq_chk
  import spq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [5:0]        wlow,
  input logic              eng_busy,
  input logic              eng_done,
  input logic              eng_tx_req,
  input logic              eng_rx_valid,
  input logic              irq,
  input logic [NUM_ST-1:0] status,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt
);
  logic unused_chk;
  assign unused_chk = ^{status[ST_PEND], status[ST_RXHI:ST_TXLO], wlow[5]};

  // R2
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  // R4
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_RXD && rx_cnt == '0 && !eng_rx_valid) |=> (rx_cnt == '0));

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> status[ST_DONE]);

  // R7
  tx_starve_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && eng_tx_req && tx_cnt == '0) |=> status[ST_TXUF]);

  // R8
  rx_drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_valid && rx_cnt == CW'(DEPTH)) |=> status[ST_RXOF]);

  // R9
  w1c_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && wlow[ST_DONE] && !eng_done) |=> !status[ST_DONE]);

  // R10
  irq_off_after_mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_IEN && wlow[4:0] == 5'd0) |=> !irq);
endmodule

bind spi_buf_irq_unit spq_chk #(.DEPTH(DEPTH), .CW(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .wlow(reg_wdata[5:0]), .eng_busy(eng_busy), .eng_done(eng_done),
  .eng_tx_req(eng_tx_req), .eng_rx_valid(eng_rx_valid), .irq(irq),
  .status(status), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_spi_buf_irq_unit.sv
`timescale 1ns/1ps
module test_spi_buf_irq_unit;
  localparam int DW = 32;
  localparam int D  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          eng_busy = 1'b0, eng_done = 1'b0, eng_tx_req = 1'b0, eng_rx_valid = 1'b0;
  logic [DW-1:0] eng_tx_word;
  logic [DW-1:0] eng_rx_word = '0;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  spi_buf_irq_unit #(.DATA_W(DW), .DEPTH(D)) i_spi_buf_irq_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
    .eng_done(eng_done), .eng_tx_req(eng_tx_req), .eng_tx_word(eng_tx_word),
    .eng_rx_valid(eng_rx_valid), .eng_rx_word(eng_rx_word), .irq(irq)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic tx_pop(output logic [DW-1:0] d);
    @(negedge clk);
    eng_tx_req = 1'b1;
    #1 d = eng_tx_word;
    @(posedge clk); #1;
    eng_tx_req = 1'b0;
  endtask

  task automatic rx_push(input logic [DW-1:0] d);
    @(negedge clk);
    eng_rx_word = d; eng_rx_valid = 1'b1;
    @(posedge clk); #1;
    eng_rx_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    eng_done = 1'b1;
    @(posedge clk); #1;
    eng_done = 1'b0;
  endtask

  function automatic logic [DW-1:0] wc(input int rxc, input int txc);
    return DW'(txc * 16 + rxc);
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic          exp_irq;

    // R1 reset state
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R1 status in reset", v, 0);
    rd(3'd3, v); chk("R1 wcnt in reset", v, 0);
    rd(3'd1, v); chk("R1 ien in reset", v, 0);
    chk("R1 irq in reset", DW'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    rd(3'd2, v); chk("R1 thr after reset", v, 32'h80);

    // R2 / R4: fill transmit queue past full
    for (int k = 0; k < D + 1; k++) begin
      wr(3'd4, 32'hA500_0000 + DW'(k));
      rd(3'd3, v); chk("R2 R4 tx count", v, wc(0, imin(k + 1, D)));
    end
    for (int k = 0; k < D; k++) begin
      tx_pop(v); chk("R2 tx order", v, 32'hA500_0000 + DW'(k));
    end
    rd(3'd0, v); chk("R7 no starve when idle", v & 32'h10, 0);
    eng_busy = 1'b1;
    tx_pop(v); chk("R7 starve data", v, 0);
    rd(3'd0, v); chk("R7 starve flag", v & 32'h10, 32'h10);
    chk("R5 pending bit", v & 32'h1, 1);
    wr(3'd0, 32'h3F);
    rd(3'd0, v); chk("R5 pending not cleared", v & 32'h1, 1);
    eng_busy = 1'b0;
    wr(3'd0, 32'h3F);
    rd(3'd0, v); chk("R9 cleared leaves tx low", v, 32'h04);

    // R3 / R8 / R4: receive queue
    for (int k = 0; k < D + 1; k++) begin
      rx_push(32'h5A00_0000 + DW'(k));
      rd(3'd3, v); chk("R3 R8 rx count", v, wc(imin(k + 1, D), 0));
    end
    rd(3'd0, v); chk("R8 drop flag", v & 32'h20, 32'h20);
    for (int k = 0; k < D; k++) begin
      rd(3'd5, v); chk("R3 rx order", v, 32'h5A00_0000 + DW'(k));
    end
    rd(3'd5, v); chk("R4 empty read zero", v, 0);
    rd(3'd3, v); chk("R4 empty read count", v, 0);

    // R6: sweep occupancy and marks
    for (int c = 0; c <= D; c++) begin
      for (int k = 0; k < c; k++) wr(3'd4, DW'(k));
      for (int k = 0; k < D - c; k++) rx_push(DW'(k));
      for (int lvl = 0; lvl <= D; lvl++) begin
        wr(3'd2, DW'(lvl * 16 + lvl));
        wr(3'd0, 32'h3F);
        rd(3'd0, v);
        chk("R6 threshold flags", v & 32'h0C,
            ((D - c) >= lvl ? 32'h08 : 32'h0) | (c <= lvl ? 32'h04 : 32'h0));
      end
      for (int k = 0; k < c; k++) tx_pop(v);
      for (int k = 0; k < D - c; k++) rd(3'd5, v);
    end
    wr(3'd2, 32'h80);

    // R5 / R9: done sticky, write-one clear, set wins
    wr(3'd0, 32'h3F);
    done_pulse();
    rd(3'd0, v); chk("R5 done set", v & 32'h2, 32'h2);
    wr(3'd0, 32'h00);
    rd(3'd0, v); chk("R9 zero write keeps", v & 32'h2, 32'h2);
    wr(3'd0, 32'h02);
    rd(3'd0, v); chk("R9 one write clears", v & 32'h2, 0);
    @(negedge clk);
    reg_addr = 3'd0; reg_wdata = 32'h02; reg_wr = 1'b1; eng_done = 1'b1;
    @(posedge clk); #1; reg_wr = 1'b0; eng_done = 1'b0;
    rd(3'd0, v); chk("R9 set wins over clear", v & 32'h2, 32'h2);

    // R10: enable sweep with two status mixes
    for (int s = 0; s < 2; s++) begin
      if (s == 1) begin
        eng_busy = 1'b1; tx_pop(v); eng_busy = 1'b0;
        for (int k = 0; k < D + 1; k++) rx_push(DW'(k));
      end
      for (int e = 0; e < 32; e++) begin
        wr(3'd1, DW'(e));
        rd(3'd0, v);
        exp_irq = |(v[5:1] & 5'(e));
        chk("R10 irq mask", DW'(irq), DW'(exp_irq));
      end
      wr(3'd1, 32'h1F);
      wr(3'd1, 32'h00);
      @(negedge clk); chk("R10 irq off after mask clear", DW'(irq), 0);
    end
    for (int k = 0; k < D; k++) rd(3'd5, v);

    // R11: same-cycle push and pop
    for (int k = 0; k < D; k++) wr(3'd4, 32'hB000_0000 + DW'(k));
    @(negedge clk);
    reg_addr = 3'd4; reg_wdata = 32'hDEAD_BEEF; reg_wr = 1'b1; eng_tx_req = 1'b1;
    #1 v = eng_tx_word; chk("R11 full pop data", v, 32'hB000_0000);
    @(posedge clk); #1; reg_wr = 1'b0; eng_tx_req = 1'b0;
    rd(3'd3, v); chk("R11 full write lost", v, wc(0, D - 1));
    for (int k = 1; k < D; k++) begin
      tx_pop(v); chk("R11 tx drain", v, 32'hB000_0000 + DW'(k));
    end
    @(negedge clk);
    reg_addr = 3'd5; reg_rd = 1'b1; eng_rx_word = 32'hC0FF_EE01; eng_rx_valid = 1'b1;
    #1 v = reg_rdata; chk("R11 empty read with push", v, 0);
    @(posedge clk); #1; reg_rd = 1'b0; eng_rx_valid = 1'b0;
    rd(3'd3, v); chk("R11 push kept", v, wc(1, 0));
    rd(3'd5, v); chk("R11 pushed word", v, 32'hC0FF_EE01);
    for (int k = 0; k < 3; k++) wr(3'd4, 32'hD000_0000 + DW'(k));
    @(negedge clk);
    reg_addr = 3'd4; reg_wdata = 32'hD000_0003; reg_wr = 1'b1; eng_tx_req = 1'b1;
    #1 v = eng_tx_word; chk("R11 mid pop data", v, 32'hD000_0000);
    @(posedge clk); #1; reg_wr = 1'b0; eng_tx_req = 1'b0;
    rd(3'd3, v); chk("R11 mid count kept", v, wc(0, 3));
    for (int k = 1; k < 4; k++) begin
      tx_pop(v); chk("R11 mid drain", v, 32'hD000_0000 + DW'(k));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule